// File: doc/BRIEF.md
# Interleaved Bank Controller for a Strobe-Based Processor Bus

This block serves a small processor on an 8-bit data, 16-bit address bus that uses active-low strobes: a memory request, a read and a write. Behind it are four independent memory banks, and each one is enabled through its own chip select. The two lowest address bits pick the bank, so a run of consecutive addresses walks through all four banks in turn. A bank is slow, and the controller drives an active-high stall line to hold the processor until the chosen bank has finished.

Every bank stays busy for a fixed recovery window after it starts an access. That window can be longer than the stall the processor sees. When the next request goes to a different bank, it starts at once. When it goes back to a bank that is still recovering, the stall is stretched until that bank is free. The latency figures are parameters, so one design can match banks of different speeds.

A read result stays on the data output while the request and read strobes remain low. The controller returns to idle only after the processor raises the memory request.

Top module: `ilv_bus_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `stall`, `bank_cs` and `dout` are all zero, and `dout_en` is low while the strobes are high.
- R2: With `mreq_n` low, a read is `rd_n`=0 and `wr_n`=1, and a write is `wr_n`=0 and `rd_n`=1. If both strobes are low, or both are high, nothing happens: `stall` stays low, no chip select rises and no memory word changes.
- R3: The bank is `addr[1:0]` and the word inside the bank is `addr[9:2]`. `addr[15:10]` is ignored, so those addresses alias. At most one bit of `bank_cs` is high at a time. While a bank performs an access, only bit `addr[1:0]` is high, and it stays high through the final stall cycle.
- R4: `stall` rises on the first clock edge after a valid request is sampled. If the bank is free, `stall` stays high for exactly ACC_WAIT cycles.
- R5: A bank stays busy for BANK_BUSY cycles, counted from the edge that starts its access. A request to a busy bank keeps `stall` high until the bank is free, then for ACC_WAIT cycles more.
- R6: Back-to-back requests to consecutive addresses each see only ACC_WAIT stall cycles, because each one lands in a different bank.
- R7: A read returns the byte most recently written to the same bank and word. The byte is on `dout` from the cycle `stall` falls.
- R8: `dout_en` is high exactly when `mreq_n`=0, `rd_n`=0 and `wr_n`=1, and low otherwise.
- R9: After `stall` falls, the controller keeps its result and starts no new access until `mreq_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | Memory request, active low, valid address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 16 | Byte address |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_en | output | 1 | High when the controller drives the data bus |
| stall | output | 1 | Active-high wait to the processor |
| bank_cs | output | 4 | One-hot chip select of the bank being accessed |

## Verification
On every cycle, the assertions check the local rules of the handshake: a stall that follows each accepted request, a quiet stall after idle or conflicting strobes, a stall that falls only out of the counting phase, a stall held while the bank is busy, a result held until release, chip selects that are never more than one-hot, and no bank started while it is still recovering. Some things only the bench scenarios can show. These are the exact stall lengths when a bank is free and when it is busy, the overlap gained from consecutive addresses, address aliasing, and that read data matches earlier writes. To check these, the bench keeps its own per-bank model of free times and memory contents.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_ACC,
    ST_DONE
  } ilv_state_e;
endpackage

// File: rtl/ilv_strobe_dec.sv
module ilv_strobe_dec (
  input  logic mreq_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_req,
  output logic wr_req
);
  // exactly one strobe low qualifies; both low or both high is a no-op
  assign rd_req = !mreq_n && !rd_n &&  wr_n;
  assign wr_req = !mreq_n &&  rd_n && !wr_n;
endmodule

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int DATA_W    = 8,
  parameter int ROW_W     = 8,
  parameter int BANK_BUSY = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wdata,
  output logic              free,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH  = 1 << ROW_W;
  localparam int BUSY_W = $clog2(BANK_BUSY + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [BUSY_W-1:0] busy;

  // recovery counter: loaded at access start, bank free again at zero
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= '0;
    end else if (issue) begin
      busy <= BUSY_W'(BANK_BUSY - 1);
    end else if (busy != '0) begin
      busy <= busy - 1'b1;
    end
  end

  assign free = (busy == '0);

  // single-port array with registered read, enabled on access start
  always_ff @(posedge clk) begin
    if (issue) begin
      if (we) begin
        mem[row] <= wdata;
      end
      rdata <= mem[row];
    end
  end

  // R5: the front end never starts a bank that is still recovering
  p_issue_free_r5: assert property (@(posedge clk) disable iff (rst)
    issue |-> (busy == '0));
endmodule

// File: rtl/ilv_front.sv
module ilv_front
  import ilv_pkg::*;
#(
  parameter int NB       = 4,
  parameter int SEL_W    = 2,
  parameter int ROW_W    = 8,
  parameter int DATA_W   = 8,
  parameter int ACC_WAIT = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mreq_n,
  input  logic                       rd_req,
  input  logic                       wr_req,
  input  logic [SEL_W-1:0]           in_sel,
  input  logic [ROW_W-1:0]           in_row,
  input  logic [DATA_W-1:0]          in_wdata,
  input  logic [NB-1:0]              bank_free,
  input  logic [NB-1:0][DATA_W-1:0]  bank_rdata,
  output logic                       issue,
  output logic [SEL_W-1:0]           issue_sel,
  output logic [ROW_W-1:0]           issue_row,
  output logic                       issue_we,
  output logic [DATA_W-1:0]          issue_wdata,
  output logic                       stall_o,
  output logic [NB-1:0]              bank_cs,
  output logic [DATA_W-1:0]          rdata
);
  localparam int ACC_W = $clog2(ACC_WAIT + 1);
  localparam logic [NB-1:0] ONE = NB'(1);

  ilv_state_e        state;
  logic [SEL_W-1:0]  sel_q;
  logic [ROW_W-1:0]  row_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic [ACC_W-1:0]  acc_cnt;
  logic              start;

  assign start = (state == ST_IDLE) && (rd_req || wr_req);

  // the access starts straight from the pins when idle, else from the latch
  always_comb begin
    if (state == ST_IDLE) begin
      issue       = start && bank_free[in_sel];
      issue_sel   = in_sel;
      issue_row   = in_row;
      issue_we    = wr_req;
      issue_wdata = in_wdata;
    end else begin
      issue       = (state == ST_HOLD) && bank_free[sel_q];
      issue_sel   = sel_q;
      issue_row   = row_q;
      issue_we    = we_q;
      issue_wdata = wdata_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sel_q   <= '0;
      row_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      acc_cnt <= '0;
      stall_o <= 1'b0;
      bank_cs <= '0;
      rdata   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            sel_q   <= in_sel;
            row_q   <= in_row;
            we_q    <= wr_req;
            wdata_q <= in_wdata;
            stall_o <= 1'b1;
            if (bank_free[in_sel]) begin
              state   <= ST_ACC;
              acc_cnt <= ACC_W'(ACC_WAIT);
              bank_cs <= ONE << in_sel;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          if (bank_free[sel_q]) begin
            state   <= ST_ACC;
            acc_cnt <= ACC_W'(ACC_WAIT);
            bank_cs <= ONE << sel_q;
          end
        end
        ST_ACC: begin
          if (acc_cnt == ACC_W'(1)) begin
            state   <= ST_DONE;
            stall_o <= 1'b0;
            bank_cs <= '0;
            if (!we_q) begin
              rdata <= bank_rdata[sel_q];
            end
          end else begin
            acc_cnt <= acc_cnt - 1'b1;
          end
        end
        default: begin
          if (mreq_n) begin
            state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R4: an accepted request raises stall on the next edge
  p_stall_on_start_r4: assert property (@(posedge clk) disable iff (rst)
    start |=> stall_o);

  // R2: idle with no valid strobe pair keeps the processor running
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start) |=> !stall_o);

  // R4: stall is released only from the counting phase
  p_stall_fall_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> ($past(state) == ST_ACC));

  // R5: a busy target bank keeps stall asserted
  p_hold_stalls_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !bank_free[sel_q]) |=> stall_o);

  // R3: at most one chip select at a time
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_cs));

  // R9: result held, no restart, until the request strobe is released
  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !mreq_n) |=> (state == ST_DONE && !stall_o && $stable(rdata)));
endmodule

// File: rtl/ilv_bus_ctrl.sv
module ilv_bus_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int NB        = 4,
  parameter int ROW_W     = 8,
  parameter int ACC_WAIT  = 3,
  parameter int BANK_BUSY = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              stall,
  output logic [NB-1:0]     bank_cs
);
  localparam int SEL_W = $clog2(NB);
  localparam int USED_W = SEL_W + ROW_W;

  logic                      rd_req;
  logic                      wr_req;
  logic                      issue;
  logic [SEL_W-1:0]          issue_sel;
  logic [ROW_W-1:0]          issue_row;
  logic                      issue_we;
  logic [DATA_W-1:0]         issue_wdata;
  logic [NB-1:0]             bank_free;
  logic [NB-1:0][DATA_W-1:0] bank_rdata;
  logic                      unused_hi_addr;

  assign unused_hi_addr = ^addr[ADDR_W-1:USED_W];

  ilv_strobe_dec u_dec (
    .mreq_n (mreq_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .rd_req (rd_req),
    .wr_req (wr_req)
  );

  ilv_front #(
    .NB       (NB),
    .SEL_W    (SEL_W),
    .ROW_W    (ROW_W),
    .DATA_W   (DATA_W),
    .ACC_WAIT (ACC_WAIT)
  ) u_front (
    .clk         (clk),
    .rst         (rst),
    .mreq_n      (mreq_n),
    .rd_req      (rd_req),
    .wr_req      (wr_req),
    .in_sel      (addr[SEL_W-1:0]),
    .in_row      (addr[USED_W-1:SEL_W]),
    .in_wdata    (din),
    .bank_free   (bank_free),
    .bank_rdata  (bank_rdata),
    .issue       (issue),
    .issue_sel   (issue_sel),
    .issue_row   (issue_row),
    .issue_we    (issue_we),
    .issue_wdata (issue_wdata),
    .stall_o     (stall),
    .bank_cs     (bank_cs),
    .rdata       (dout)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    ilv_bank #(
      .DATA_W    (DATA_W),
      .ROW_W     (ROW_W),
      .BANK_BUSY (BANK_BUSY)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .issue (issue && (issue_sel == SEL_W'(i))),
      .we    (issue_we),
      .row   (issue_row),
      .wdata (issue_wdata),
      .free  (bank_free[i]),
      .rdata (bank_rdata[i])
    );
  end

  // R8: the data bus is driven only for a qualified read
  assign dout_en = rd_req;
endmodule

// File: tb/tb_ilv_bus_ctrl.sv
module tb_ilv_bus_ctrl;
  localparam int ACC  = 3;
  localparam int BUSY = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, stall;
  logic [3:0]  bank_cs;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] model_mem [1024];
  int free_at [4];
  int last_n;

  ilv_bus_ctrl #(.ACC_WAIT(ACC), .BANK_BUSY(BUSY)) dut (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .stall(stall), .bank_cs(bank_cs)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_stall(input int e0, input int b);
    int iss;
    iss = (free_at[b] > e0) ? free_at[b] : e0;
    return iss - e0 + ACC;
  endfunction

  // one processor access; hold = extra cycles the strobes stay low after stall falls
  task automatic access(input bit wr, input logic [15:0] a, input logic [7:0] d, input int hold);
    int e0, b, n, expn;
    logic [3:0] cs_seen;
    @(negedge clk);
    addr = a; din = d; mreq_n = 1'b0; rd_n = wr; wr_n = !wr;
    e0 = cyc + 1;
    b = int'(a[1:0]);
    expn = exp_stall(e0, b);
    n = 0; cs_seen = '0;
    @(negedge clk);
    while (stall && n < 500) begin
      n++; cs_seen = bank_cs;
      @(negedge clk);
    end
    last_n = n;
    chk(n == expn, "R4/R5 stall length", n, expn);
    chk(cs_seen == (4'b1 << b), "R3 chip select", cs_seen, 4'b1 << b);
    free_at[b] = e0 + expn - ACC + BUSY;
    if (wr) model_mem[a[9:0]] = d;
    else begin
      chk(dout == model_mem[a[9:0]], "R7 read data", dout, model_mem[a[9:0]]);
      chk(dout_en == 1'b1, "R8 drive on read", dout_en, 1);
    end
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(stall == 1'b0, "R9 no restart while held", stall, 0);
      if (!wr) chk(dout == model_mem[a[9:0]], "R9 data held", dout, model_mem[a[9:0]]);
    end
    mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
    chk(dout_en == 1'b0, "R8 release", dout_en, 0);
  endtask

  // strobe pattern that must do nothing
  task automatic nop(input logic [15:0] a, input logic both_low);
    @(negedge clk);
    addr = a; din = 8'h5A; mreq_n = 1'b0; rd_n = !both_low; wr_n = !both_low;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(stall == 1'b0, "R2 no stall on no-op", stall, 0);
      chk(bank_cs == 4'b0, "R2 no chip select on no-op", bank_cs, 0);
      chk(dout_en == 1'b0, "R8 no drive on no-op", dout_en, 0);
    end
    mreq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) free_at[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stall == 1'b0 && bank_cs == 4'b0, "R1 reset outputs", {stall, bank_cs}, 0);
    chk(dout == 8'h00 && dout_en == 1'b0, "R1 reset data", {dout_en, dout}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(stall == 1'b0 && bank_cs == 4'b0, "R1 after reset", {stall, bank_cs}, 0);

    // fill every word; consecutive addresses also exercise overlap
    for (int i = 0; i < 1024; i++) access(1'b1, 16'(i), 8'(i * 7 + 3), 0);

    // R6: consecutive addresses, each pays only the base stall
    repeat (10) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      access(1'b0, 16'h0100 + 16'(i), 8'h00, 0);
      chk(last_n == ACC, "R6 interleaved stall", last_n, ACC);
    end

    // R5: same bank twice in a row extends stall
    repeat (10) @(negedge clk);
    access(1'b1, 16'h0044, 8'hC3, 0);
    access(1'b0, 16'h0044, 8'h00, 0);
    chk(last_n > ACC, "R5 busy bank extends stall", last_n, ACC + 1);

    // R3: high address bits alias
    access(1'b1, 16'hFC21, 8'h9E, 0);
    access(1'b0, 16'h0421, 8'h00, 0);
    chk(dout == 8'h9E, "R3 alias read", dout, 8'h9E);

    // R9: strobes held after stall falls
    access(1'b0, 16'h0013, 8'h00, 3);
    access(1'b1, 16'h0017, 8'h3C, 2);

    // R2: conflicting and empty strobe pairs, then verify memory untouched
    nop(16'h0030, 1'b1);
    nop(16'h0031, 1'b0);
    access(1'b0, 16'h0030, 8'h00, 0);
    access(1'b0, 16'h0031, 8'h00, 0);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int op, g;
      logic [15:0] a;
      op = int'($urandom_range(0, 9));
      a = 16'($urandom);
      if ($urandom_range(0, 1) == 1) a[1:0] = addr[1:0];
      if (op == 0) nop(a, 1'($urandom_range(0, 1)));
      else access(op < 5, a, 8'($urandom), int'($urandom_range(0, 1)));
      g = int'($urandom_range(0, 2));
      repeat (g) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule